// File: doc/BRIEF.md
# Open-Drain Serial Clock Generator with Pre-Clock and Post-Address Hold

This block produces the serial clock of a byte-oriented two-wire bus master. It never drives the clock line high: it either pulls the line low or lets it go, and it watches the resolved wire level through a two-stage synchronizer. Because of this, a device elsewhere on the bus can stretch any high phase by keeping the line low. A write to the transmit buffer starts a byte. A programmable lead window comes first. Then nine bit clocks follow: eight data bits and one acknowledge bit. After the ninth falling edge a done pulse is issued and the line is left low.

Two control bits close timing holes around the byte. With the early-hold bit set, the block pulls the clock low from the moment the write is accepted. This only applies in master mode and only after a start condition has been reported. Other devices then wait during the lead window instead of clocking a stray bit into it. With the post-byte hold bit set, the clock stays low after the eighth falling edge so that software can compare the received address. Clearing the bit resumes clocking with the ninth bit.

The block carries no data stream, so there is no valid/ready handshake and no back-pressure to describe. Every pin is a plain control or status level or a single-cycle strobe.

Top module: `i2c_scl_gen`

## Requirements
- R1: After reset, `scl_low_o`, `irq_o` and `done_o` are 0 and `bit_cnt_o` is 0.
- R2: The phase length is h = max(`half_period`, 2) system clocks. Each low phase lasts h clocks. Each high phase counts h clocks in which the synchronized line is high, and the synchronizer adds 2 clocks. Without stretching, the done pulse is set LEAD_PHASES*h + 9*(2h+2) clocks after the edge that accepts the write.
- R3: The lead window lasts LEAD_PHASES half phases (default 3, which is 1.5 clock periods) from the accepting edge. During it the block does not look at `scl_in`, so the line level has no effect on timing.
- R4: When `master_en`=1, `early_hold_en`=1 and a `start_done` pulse has been seen since `master_en` last rose, `scl_low_o` is 1 from the accepting edge through the whole lead window.
- R5: When `early_hold_en`=0, `master_en`=0 or no start has been reported, `scl_low_o` is 0 during the lead window. The start record is cleared while `master_en` is 0.
- R6: Each clock of line-low time during a released high phase, from bit 1 onward, delays the end of that phase by one clock.
- R7: With `byte_hold_en`=1 at the eighth falling edge, `scl_low_o` stays 1 and `bit_cnt_o` stays 8 until `byte_hold_en` is 0. The ninth bit then runs one low phase and one high phase, and done is set 2h+2 clocks after the edge at which `byte_hold_en` is seen at 0.
- R8: On entry to the post-byte hold, `irq_o` is high for exactly one cycle if `i2c_mode`=1. It stays 0 if `i2c_mode`=0.
- R9: At the ninth falling edge, `done_o` pulses for one cycle, `bit_cnt_o` returns to 0 and `scl_low_o` stays 1 until the next accepted write.
- R10: A `tx_write` pulse while a byte is in progress is ignored. The byte's timing is unchanged.
- R11: `bit_cnt_o` is 0 when idle and during the lead window. It becomes 1 at the start of the first low phase, rises by one at each falling edge, and never exceeds 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| master_en | input | 1 | Block acts as bus master |
| i2c_mode | input | 1 | Enables the interrupt pulse at the post-byte hold |
| early_hold_en | input | 1 | Pull the clock low from the buffer write until clocking starts |
| byte_hold_en | input | 1 | Hold the clock low after the eighth bit |
| half_period | input | DIV_W | Phase length in system clocks (values below 2 act as 2) |
| start_done | input | 1 | Pulse: a start condition has been generated |
| tx_write | input | 1 | Pulse: transmit buffer written, which starts a byte when idle |
| scl_in | input | 1 | Resolved clock-line level |
| scl_low_o | output | 1 | 1 pulls the clock line low, 0 releases it |
| bit_cnt_o | output | 4 | Current bit number, 0 to 9 |
| irq_o | output | 1 | One-cycle receive interrupt at the post-byte hold |
| done_o | output | 1 | One-cycle pulse after the ninth falling edge |

## Verification
Output timing is counted from the edge W that accepts the write. The bench samples on falling edges, so the value registered at W+k is read at the k+1-th falling edge. Lead-window drive is read over falling edges 1 to 3h, the first bit number at 3h+1, and done at 21h+19 (default lead). Each line-low clock injected into a high phase adds one to that figure. For the post-byte hold, done falls exactly 2h+3 falling edges after the one at which the hold bit is cleared. The interrupt is read at every falling edge so that a pulse of the wrong width is counted.

// File: rtl/i2c_scl_gen_pkg.sv
package i2c_scl_gen_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_LOW,
    ST_HIGH,
    ST_HOLD
  } scl_state_e;

  localparam int unsigned BIT_ADDR_LAST = 8;
  localparam int unsigned BIT_ACK       = 9;
  localparam int unsigned MIN_PHASE     = 2;
endpackage

// File: rtl/scl_sync.sv
module scl_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic q_out
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= 1'b1;
          else        chain[0] <= d_in;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[i] <= 1'b1;
          else        chain[i] <= chain[i-1];
      end
    end
  endgenerate

  assign q_out = chain[STAGES-1];
endmodule

// File: rtl/scl_phase_timer.sv
module scl_phase_timer #(
  parameter int unsigned W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         en,
  output logic         expire
);
  logic [W-1:0] cnt;

  assign expire = en && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= '0;
    else if (load)              cnt <= load_val;
    else if (en && cnt != '0)   cnt <= cnt - 1'b1;
  end
endmodule

// File: rtl/scl_ctrl.sv
module scl_ctrl
  import i2c_scl_gen_pkg::*;
#(
  parameter int unsigned DIV_W       = 8,
  parameter int unsigned LEAD_PHASES = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             master_en,
  input  logic             i2c_mode,
  input  logic             early_hold_en,
  input  logic             byte_hold_en,
  input  logic [DIV_W-1:0] half_period,
  input  logic             start_done,
  input  logic             tx_write,
  input  logic             line_high,
  output logic             scl_low_o,
  output logic [3:0]       bit_cnt_o,
  output logic             irq_o,
  output logic             done_o,
  output logic             busy_o,
  output logic             start_seen_o
);
  localparam int unsigned CNT_W = DIV_W + 2;

  scl_state_e state;
  logic [DIV_W-1:0] h_eff;
  logic [CNT_W-1:0] phase_val, lead_val, tmr_val;
  logic tmr_load, tmr_en, tmr_expire;
  logic start_seen, arm_early;

  assign h_eff     = (half_period < DIV_W'(MIN_PHASE)) ? DIV_W'(MIN_PHASE) : half_period;
  assign phase_val = CNT_W'(h_eff) - 1'b1;
  assign lead_val  = CNT_W'(LEAD_PHASES) * CNT_W'(h_eff) - 1'b1;
  assign arm_early = master_en && early_hold_en && start_seen;

  always_comb begin
    tmr_en   = (state == ST_LEAD) || (state == ST_LOW) ||
               ((state == ST_HIGH) && line_high);
    tmr_load = 1'b0;
    tmr_val  = phase_val;
    if (state == ST_IDLE && tx_write) begin
      tmr_load = 1'b1;
      tmr_val  = lead_val;
    end else if (tmr_expire || (state == ST_HOLD && !byte_hold_en)) begin
      tmr_load = 1'b1;
    end
  end

  scl_phase_timer #(.W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .en       (tmr_en),
    .expire   (tmr_expire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      scl_low_o  <= 1'b0;
      bit_cnt_o  <= '0;
      irq_o      <= 1'b0;
      done_o     <= 1'b0;
      start_seen <= 1'b0;
    end else begin
      irq_o  <= 1'b0;
      done_o <= 1'b0;
      if (!master_en)      start_seen <= 1'b0;
      else if (start_done) start_seen <= 1'b1;

      unique case (state)
        ST_IDLE: if (tx_write) begin
          state     <= ST_LEAD;
          scl_low_o <= arm_early;
          bit_cnt_o <= '0;
        end
        ST_LEAD: if (tmr_expire) begin
          state     <= ST_LOW;
          scl_low_o <= 1'b1;
          bit_cnt_o <= 4'd1;
        end
        ST_LOW: if (tmr_expire) begin
          state     <= ST_HIGH;
          scl_low_o <= 1'b0;
        end
        ST_HIGH: if (tmr_expire) begin
          scl_low_o <= 1'b1;
          if (bit_cnt_o == 4'(BIT_ACK)) begin
            state     <= ST_IDLE;
            bit_cnt_o <= '0;
            done_o    <= 1'b1;
          end else if (bit_cnt_o == 4'(BIT_ADDR_LAST) && byte_hold_en) begin
            state <= ST_HOLD;
            irq_o <= i2c_mode;
          end else begin
            state     <= ST_LOW;
            bit_cnt_o <= bit_cnt_o + 1'b1;
          end
        end
        ST_HOLD: if (!byte_hold_en) begin
          state     <= ST_LOW;
          bit_cnt_o <= 4'(BIT_ACK);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy_o       = (state != ST_IDLE);
  assign start_seen_o = start_seen;
endmodule

// File: rtl/i2c_scl_gen.sv
module i2c_scl_gen #(
  parameter int unsigned DIV_W       = 8,
  parameter int unsigned LEAD_PHASES = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             master_en,
  input  logic             i2c_mode,
  input  logic             early_hold_en,
  input  logic             byte_hold_en,
  input  logic [DIV_W-1:0] half_period,
  input  logic             start_done,
  input  logic             tx_write,
  input  logic             scl_in,
  output logic             scl_low_o,
  output logic [3:0]       bit_cnt_o,
  output logic             irq_o,
  output logic             done_o
);
  logic line_high;
  logic busy;
  logic start_seen;

  scl_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  (scl_in),
    .q_out (line_high)
  );

  scl_ctrl #(.DIV_W(DIV_W), .LEAD_PHASES(LEAD_PHASES)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .master_en     (master_en),
    .i2c_mode      (i2c_mode),
    .early_hold_en (early_hold_en),
    .byte_hold_en  (byte_hold_en),
    .half_period   (half_period),
    .start_done    (start_done),
    .tx_write      (tx_write),
    .line_high     (line_high),
    .scl_low_o     (scl_low_o),
    .bit_cnt_o     (bit_cnt_o),
    .irq_o         (irq_o),
    .done_o        (done_o),
    .busy_o        (busy),
    .start_seen_o  (start_seen)
  );
endmodule

// File: rtl/i2c_scl_gen_chk.sv
module i2c_scl_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       master_en,
  input logic       early_hold_en,
  input logic       byte_hold_en,
  input logic       tx_write,
  input logic       busy,
  input logic       start_seen,
  input logic       scl_low_o,
  input logic [3:0] bit_cnt_o,
  input logic       irq_o,
  input logic       done_o
);
  a_r11_bit_range: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt_o <= 4'd9);

  a_r11_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> bit_cnt_o == 4'd0);

  a_r9_done_parks: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (scl_low_o && bit_cnt_o == 4'd0 && !busy));

  a_r8_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o);

  a_r7_irq_in_hold: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (scl_low_o && bit_cnt_o == 4'd8));

  a_r7_hold_keeps_low: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && byte_hold_en) |=> scl_low_o);

  a_r4_early_low: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_write && !busy && master_en && early_hold_en && start_seen) |=> scl_low_o);

  a_r5_no_master_release: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_write && !busy && (!master_en || !early_hold_en)) |=> !scl_low_o);

  a_r10_busy_write: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_write && busy) |=> (busy || done_o));
endmodule

bind i2c_scl_gen i2c_scl_gen_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .master_en     (master_en),
  .early_hold_en (early_hold_en),
  .byte_hold_en  (byte_hold_en),
  .tx_write      (tx_write),
  .busy          (busy),
  .start_seen    (start_seen),
  .scl_low_o     (scl_low_o),
  .bit_cnt_o     (bit_cnt_o),
  .irq_o         (irq_o),
  .done_o        (done_o)
);

// File: tb/i2c_scl_gen_bench.sv
`timescale 1ns/1ps
module i2c_scl_gen_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic master_en = 1'b0, i2c_mode = 1'b0, early_hold_en = 1'b0, byte_hold_en = 1'b0;
  logic [7:0] half_period = 8'd4;
  logic start_done = 1'b0, tx_write = 1'b0, ext_low = 1'b0;
  logic scl_in, scl_low_o, irq_o, done_o;
  logic [3:0] bit_cnt_o;

  int tests = 0, fails = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;
  assign scl_in = !(scl_low_o || ext_low);

  i2c_scl_gen u_i2c_scl_gen (
    .clk(clk), .rst_n(rst_n), .master_en(master_en), .i2c_mode(i2c_mode),
    .early_hold_en(early_hold_en), .byte_hold_en(byte_hold_en),
    .half_period(half_period), .start_done(start_done), .tx_write(tx_write),
    .scl_in(scl_in), .scl_low_o(scl_low_o), .bit_cnt_o(bit_cnt_o),
    .irq_o(irq_o), .done_o(done_o)
  );

  // vector: {half_period, master_en, start reported, early_hold_en}
  localparam logic [10:0] VEC [6] = '{
    {8'd4, 1'b1, 1'b1, 1'b1},
    {8'd4, 1'b1, 1'b1, 1'b0},
    {8'd5, 1'b0, 1'b1, 1'b1},
    {8'd3, 1'b1, 1'b0, 1'b1},
    {8'd0, 1'b1, 1'b1, 1'b1},
    {8'd7, 1'b1, 1'b1, 1'b0}
  };

  int ext_from = 0, ext_len = 0, wr_at = 0;
  bit hold_mode = 1'b0;

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic setup(input bit m, input bit s, input bit e);
    master_en = 1'b0;
    repeat (2) @(negedge clk);
    master_en = m;
    early_hold_en = e;
    if (s) begin
      start_done = 1'b1;
      @(negedge clk);
      start_done = 1'b0;
    end
    @(negedge clk);
  endtask

  // Runs one byte; returns lead-window low count, done index, bit number at first low phase
  task automatic run_byte(input int h, output int lead_low, output int total,
                          output int bit1, output int irqs, output int hold_low, output int hold_bit);
    int n = 0;
    int clr_at;
    lead_low = 0; total = -1; bit1 = -1; irqs = 0; hold_low = -1; hold_bit = -1;
    clr_at = 3*h + 8*(2*h+2) + 20;
    tx_write = 1'b1;
    while (n < 4000) begin
      @(negedge clk);
      n++;
      tx_write = (wr_at != 0 && n == wr_at);
      ext_low  = (ext_len != 0 && n >= ext_from && n < ext_from + ext_len);
      if (n <= 3*h && scl_low_o) lead_low++;
      if (n == 3*h + 1) bit1 = bit_cnt_o;
      if (irq_o) irqs++;
      if (hold_mode && n == clr_at) begin
        hold_low = scl_low_o;
        hold_bit = bit_cnt_o;
        byte_hold_en = 1'b0;
      end
      if (done_o) begin
        total = hold_mode ? n - clr_at : n;
        break;
      end
    end
    tx_write = 1'b0;
    ext_low = 1'b0;
  endtask

  task automatic check_park();
    int lows = 0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      if (scl_low_o && bit_cnt_o == 4'd0 && !done_o) lows++;
    end
    check("R9 park low after done", lows, 3);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      tests++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int ll, tot, b1, irqs, hl, hb, h;
    repeat (3) @(negedge clk);
    check("R1 reset scl_low", scl_low_o, 0);
    check("R1 reset bit_cnt", bit_cnt_o, 0);
    check("R1 reset irq/done", irq_o | done_o, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 6; i++) begin
      half_period = VEC[i][10:3];
      h = (VEC[i][10:3] < 2) ? 2 : int'(VEC[i][10:3]);
      setup(VEC[i][2], VEC[i][1], VEC[i][0]);
      run_byte(h, ll, tot, b1, irqs, hl, hb);
      check((VEC[i][2] && VEC[i][1] && VEC[i][0]) ? "R4 early hold lead low" : "R5 lead released",
            ll, (VEC[i][2] && VEC[i][1] && VEC[i][0]) ? 3*h : 0);
      check("R2 byte length", tot, 21*h + 19);
      check("R11 first bit number", b1, 1);
      check_park();
    end

    // R3: line pulled low through the whole lead window has no effect
    half_period = 8'd4; h = 4;
    setup(1'b1, 1'b1, 1'b0);
    ext_from = 1; ext_len = 3*h;
    run_byte(h, ll, tot, b1, irqs, hl, hb);
    check("R3 lead ignores line", tot, 21*h + 19);
    ext_len = 0;

    // R6: stretch first high phase by 10 clocks
    setup(1'b1, 1'b1, 1'b0);
    ext_from = 4*h + 1; ext_len = 10;
    run_byte(h, ll, tot, b1, irqs, hl, hb);
    check("R6 stretch extends byte", tot, 21*h + 19 + 10);
    ext_len = 0;

    // R10: write while busy ignored
    setup(1'b1, 1'b1, 1'b0);
    wr_at = 30;
    run_byte(h, ll, tot, b1, irqs, hl, hb);
    check("R10 busy write ignored", tot, 21*h + 19);
    wr_at = 0;

    // R7/R8: post-byte hold with interrupt
    half_period = 8'd3; h = 3;
    setup(1'b1, 1'b1, 1'b0);
    i2c_mode = 1'b1; byte_hold_en = 1'b1; hold_mode = 1'b1;
    run_byte(h, ll, tot, b1, irqs, hl, hb);
    check("R7 held low", hl, 1);
    check("R7 held at bit 8", hb, 8);
    check("R7 resume after clear", tot, 2*h + 3);
    check("R8 one irq pulse", irqs, 1);
    check_park();

    // R8: hold without I2C mode, no interrupt
    setup(1'b1, 1'b1, 1'b0);
    i2c_mode = 1'b0; byte_hold_en = 1'b1;
    run_byte(h, ll, tot, b1, irqs, hl, hb);
    check("R8 no irq when mode off", irqs, 0);
    check("R7 resume after clear, no irq", tot, 2*h + 3);
    hold_mode = 1'b0;

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule